// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits next to a small 16-bit processor core. It holds the program counter, the stack pointer and the status register, and it carries out the memory traffic for taking an interrupt and for returning from one. The core reports each instruction boundary with `instr_done`. The core may also move the PC forward by one word or load the status register while the sequencer is idle. When a request can be taken at a boundary, the sequencer does the following in order:

- It raises `busy`, which stalls instruction fetch.
- It pushes the return PC onto a descending stack, then the status register.
- It clears the global enable bit.
- It reads the handler address from a fixed vector word and loads it into the PC.

A return command pops the status register and then the PC. This restores the enable bit and resumes the interrupted program.

After hardware reset the block fetches the reset vector and loads the PC. It makes no stack writes on this path. Priority runs from reset, to the non-maskable request, to the maskable request. The maskable request is taken only when the global enable bit is set. Each request is acknowledged with a one-cycle pulse. The requester drops its request after seeing that pulse.

Memory traffic uses a valid/ready request channel. While `mem_req_valid` is high and `mem_req_ready` is low, the block holds the address, the write flag and the write data steady. The memory may stall for as many cycles as it needs. Only one read is outstanding at a time. Its data comes back on a later cycle, marked by `mem_rvalid`. The block is always ready for that return, so the response channel has no back-pressure.

Top module: `irq_seq_top`

## Requirements
- R1: A request is accepted only in a cycle where the block is idle and `instr_done` is high. Acceptance raises exactly one of `irq_ack` or `nmi_ack` for that single cycle.
- R2: On entry the block first writes the current PC to address SP-2 and then writes the status register to address SP-4. SP ends 4 below its value before entry.
- R3: After the two pushes the block reads the vector word and loads the PC with the returned data. The vector address is 0xFFFC for the non-maskable request and 0xFFF2 for the maskable request.
- R4: The maskable request is ignored while status register bit 3 (global enable) is 0. The non-maskable request does not depend on that bit.
- R5: When both requests are present at a boundary, the non-maskable one is taken.
- R6: The pushed status word carries the global enable bit as it stood before entry. Bit 3 of the status register reads 0 once entry has finished.
- R7: A return command issued while idle reads the status register from address SP and then the PC from address SP+2. SP rises by 2 after each pop, and both registers take the popped values.
- R8: Hardware reset sets SR to 0 and SP to SP_INIT. The block then reads address 0xFFFE and loads the PC from it, with no memory writes.
- R9: `busy` is high from the accept cycle, or the return-command cycle, until the new PC is loaded. `step_pc` and `sr_wr_en` have no effect while `busy` is high.
- R10: An unaccepted memory request keeps its valid flag, address, write flag and write data unchanged until `mem_req_ready` is seen high.
- R11: While `busy` is low, `step_pc` adds 2 to the PC and `sr_wr_en` loads the status register from `sr_wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| instr_done | input | 1 | Current instruction has completed (boundary) |
| reti_cmd | input | 1 | Return-from-interrupt command |
| irq_req | input | 1 | Maskable interrupt request (level) |
| nmi_req | input | 1 | Non-maskable interrupt request (level) |
| step_pc | input | 1 | Advance PC by one word |
| sr_wr_en | input | 1 | Load the status register |
| sr_wr_data | input | 16 | Status register load value |
| irq_ack | output | 1 | Maskable request accepted |
| nmi_ack | output | 1 | Non-maskable request accepted |
| busy | output | 1 | Stall instruction fetch |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| sr | output | 16 | Status register |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 16 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |

## Verification
On every cycle the assertions check the following:

- Acknowledges occur only at instruction boundaries and never both at once.
- A maskable acknowledge occurs only with the enable bit set.
- A stalled memory request stays steady.
- The stack pointer only ever moves by one word.
- Memory traffic happens only under `busy`.
- The PC is frozen during a sequence except at its final load.

Other behaviour can only be shown by the bench's scenarios, which compare every bus operation in order against a scoreboard. These cover:

- The exact push and pop order and addresses.
- Vector selection and the priority of the non-maskable request.
- Restoration of both registers on return.
- The reset fetch.
- That stimulus is ignored while busy or while the enable bit is clear.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [3:0] {
    S_BOOT, S_IDLE, S_PUSH_PC, S_PUSH_SR, S_VEC_REQ, S_VEC_WAIT,
    S_POPSR_REQ, S_POPSR_WAIT, S_POPPC_REQ, S_POPPC_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {SRC_NONE, SRC_NMI, SRC_IRQ} src_e;
endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb
  import irq_seq_pkg::*;
#(
  parameter int W = 16,
  parameter int GIE_BIT = 3,
  parameter logic [W-1:0] NMI_VEC = 16'hFFFC,
  parameter logic [W-1:0] IRQ_VEC = 16'hFFF2
) (
  input  logic         nmi_req,
  input  logic         irq_req,
  input  logic [W-1:0] sr,
  output src_e         sel,
  output logic [W-1:0] vec
);
  // non-maskable wins over maskable (R5); maskable gated by enable (R4)
  always_comb begin
    if (nmi_req) begin
      sel = SRC_NMI;
      vec = NMI_VEC;
    end else if (irq_req && sr[GIE_BIT]) begin
      sel = SRC_IRQ;
      vec = IRQ_VEC;
    end else begin
      sel = SRC_NONE;
      vec = IRQ_VEC;
    end
  end
endmodule

// File: rtl/irq_seq_ctl.sv
module irq_seq_ctl
  import irq_seq_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VEC = 16'hFFFE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         instr_done,
  input  logic         reti_cmd,
  input  src_e         sel,
  input  logic [W-1:0] vec,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] sp,
  input  logic [W-1:0] sr,
  input  logic         mem_req_ready,
  input  logic         mem_rvalid,
  output logic         busy,
  output logic         irq_ack,
  output logic         nmi_ack,
  output logic         mem_req_valid,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         pc_load,
  output logic         sr_load,
  output logic         sp_dec,
  output logic         sp_inc,
  output logic         gie_clr
);
  localparam logic [W-1:0] WORD = W'(2);

  seq_state_e state, state_nx;
  logic [W-1:0] vec_q;
  logic accept, ret, hs;

  assign ret    = (state == S_IDLE) && reti_cmd;
  assign accept = (state == S_IDLE) && instr_done && !reti_cmd && (sel != SRC_NONE);
  assign irq_ack = accept && (sel == SRC_IRQ);
  assign nmi_ack = accept && (sel == SRC_NMI);
  assign busy    = (state != S_IDLE) || accept || ret;

  assign mem_req_valid = (state == S_PUSH_PC) || (state == S_PUSH_SR) ||
                         (state == S_VEC_REQ) || (state == S_POPSR_REQ) ||
                         (state == S_POPPC_REQ);
  assign mem_we    = (state == S_PUSH_PC) || (state == S_PUSH_SR);
  assign mem_wdata = (state == S_PUSH_PC) ? pc : sr;

  always_comb begin
    if (mem_we)                   mem_addr = sp - WORD;
    else if (state == S_VEC_REQ)  mem_addr = vec_q;
    else                          mem_addr = sp;
  end

  assign hs      = mem_req_valid && mem_req_ready;
  assign sp_dec  = hs && mem_we;
  assign gie_clr = hs && (state == S_PUSH_SR);
  assign pc_load = mem_rvalid && ((state == S_VEC_WAIT) || (state == S_POPPC_WAIT));
  assign sr_load = mem_rvalid && (state == S_POPSR_WAIT);
  assign sp_inc  = mem_rvalid && ((state == S_POPSR_WAIT) || (state == S_POPPC_WAIT));

  always_comb begin
    state_nx = state;
    unique case (state)
      S_BOOT:       state_nx = S_VEC_REQ;
      S_IDLE:       if (ret) state_nx = S_POPSR_REQ;
                    else if (accept) state_nx = S_PUSH_PC;
      S_PUSH_PC:    if (hs) state_nx = S_PUSH_SR;
      S_PUSH_SR:    if (hs) state_nx = S_VEC_REQ;
      S_VEC_REQ:    if (hs) state_nx = S_VEC_WAIT;
      S_VEC_WAIT:   if (mem_rvalid) state_nx = S_IDLE;
      S_POPSR_REQ:  if (hs) state_nx = S_POPSR_WAIT;
      S_POPSR_WAIT: if (mem_rvalid) state_nx = S_POPPC_REQ;
      S_POPPC_REQ:  if (hs) state_nx = S_POPPC_WAIT;
      S_POPPC_WAIT: if (mem_rvalid) state_nx = S_IDLE;
      default:      state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_BOOT;
      vec_q <= RST_VEC;
    end else begin
      state <= state_nx;
      if (accept) vec_q <= vec;
    end
  end

  // R1: acknowledge only at an instruction boundary
  a_r1_ack_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack || nmi_ack) |-> instr_done);
  // R1: at most one acknowledge per cycle
  a_r1_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ack, nmi_ack}));
  // R10: stalled request holds steady
  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R9: bus traffic only while the core is stalled
  a_r9_bus_under_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);
endmodule

// File: rtl/irq_seq_regs.sv
module irq_seq_regs #(
  parameter int W = 16,
  parameter int GIE_BIT = 3,
  parameter logic [W-1:0] SP_INIT = 16'h0400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic         step_pc,
  input  logic         sr_wr_en,
  input  logic [W-1:0] sr_wr_data,
  input  logic         pc_load,
  input  logic         sr_load,
  input  logic         sp_dec,
  input  logic         sp_inc,
  input  logic         gie_clr,
  input  logic [W-1:0] rdata,
  output logic [W-1:0] pc,
  output logic [W-1:0] sp,
  output logic [W-1:0] sr
);
  localparam logic [W-1:0] WORD = W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      sp <= SP_INIT;
      sr <= '0;
    end else begin
      if (pc_load)               pc <= rdata;
      else if (step_pc && !busy) pc <= pc + WORD;

      if (sp_dec)      sp <= sp - WORD;
      else if (sp_inc) sp <= sp + WORD;

      if (sr_load)                sr <= rdata;
      else if (gie_clr)           sr[GIE_BIT] <= 1'b0;
      else if (sr_wr_en && !busy) sr <= sr_wr_data;
    end
  end

  // R2/R7: stack pointer moves one word at a time
  a_r7_sp_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> ((sp == $past(sp) - WORD) || (sp == $past(sp) + WORD)));
  // R9: PC frozen during a sequence except for its final load
  a_r9_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pc_load) |=> $stable(pc));
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
  import irq_seq_pkg::*;
#(
  parameter int W = 16,
  parameter int GIE_BIT = 3,
  parameter logic [W-1:0] SP_INIT = 16'h0400,
  parameter logic [W-1:0] RST_VEC = 16'hFFFE,
  parameter logic [W-1:0] NMI_VEC = 16'hFFFC,
  parameter logic [W-1:0] IRQ_VEC = 16'hFFF2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         instr_done,
  input  logic         reti_cmd,
  input  logic         irq_req,
  input  logic         nmi_req,
  input  logic         step_pc,
  input  logic         sr_wr_en,
  input  logic [W-1:0] sr_wr_data,
  output logic         irq_ack,
  output logic         nmi_ack,
  output logic         busy,
  output logic [W-1:0] pc,
  output logic [W-1:0] sp,
  output logic [W-1:0] sr,
  output logic         mem_req_valid,
  input  logic         mem_req_ready,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic         mem_rvalid,
  input  logic [W-1:0] mem_rdata
);
  src_e         sel;
  logic [W-1:0] vec;
  logic pc_load, sr_load, sp_dec, sp_inc, gie_clr;

  irq_seq_arb #(.W(W), .GIE_BIT(GIE_BIT), .NMI_VEC(NMI_VEC), .IRQ_VEC(IRQ_VEC)) u_arb (
    .nmi_req(nmi_req), .irq_req(irq_req), .sr(sr), .sel(sel), .vec(vec)
  );

  irq_seq_ctl #(.W(W), .RST_VEC(RST_VEC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .reti_cmd(reti_cmd),
    .sel(sel), .vec(vec), .pc(pc), .sp(sp), .sr(sr),
    .mem_req_ready(mem_req_ready), .mem_rvalid(mem_rvalid),
    .busy(busy), .irq_ack(irq_ack), .nmi_ack(nmi_ack),
    .mem_req_valid(mem_req_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pc_load(pc_load), .sr_load(sr_load),
    .sp_dec(sp_dec), .sp_inc(sp_inc), .gie_clr(gie_clr)
  );

  irq_seq_regs #(.W(W), .GIE_BIT(GIE_BIT), .SP_INIT(SP_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .busy(busy), .step_pc(step_pc),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .pc_load(pc_load),
    .sr_load(sr_load), .sp_dec(sp_dec), .sp_inc(sp_inc), .gie_clr(gie_clr),
    .rdata(mem_rdata), .pc(pc), .sp(sp), .sr(sr)
  );

  // R4: maskable acknowledge requires the enable bit
  a_r4_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> sr[GIE_BIT]);
endmodule

// File: tb/test_irq_seq_top.sv
`timescale 1ns/1ps
module test_irq_seq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_done = 0, reti_cmd = 0, irq_req = 0, nmi_req = 0, step_pc = 0, sr_wr_en = 0;
  logic [15:0] sr_wr_data = '0;
  logic irq_ack, nmi_ack, busy, mem_req_valid, mem_we;
  logic [15:0] pc, sp, sr, mem_addr, mem_wdata;
  logic mem_req_ready = 1'b1, mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;

  always #10 clk = ~clk;

  irq_seq_top i_irq_seq_top (.*);

  typedef struct packed { logic we; logic [15:0] addr; logic [15:0] data; } bus_op_t;
  bus_op_t exp_q[$];
  logic [15:0] mem [logic [15:0]];
  int vecs = 0, fails = 0;
  bit done = 0, stall = 0;
  int rd_tok = 0, rd_seen = 0;
  logic [15:0] rd_addr = '0;
  int stall_cnt = 0;

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic expect_op(logic we, logic [15:0] a, logic [15:0] d);
    exp_q.push_back('{we, a, d});
  endtask

  // monitor: every bus handshake compared in order against the scoreboard
  always @(posedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (exp_q.size() == 0) begin
        vecs++; fails++;
        $display("FAIL R2/R8: unexpected bus op we=%b addr=%h expected none", mem_we, mem_addr);
      end else begin
        bus_op_t e;
        e = exp_q.pop_front();
        check("R2/R3/R7 bus we", {15'd0, mem_we}, {15'd0, e.we});
        check("R2/R3/R7 bus addr", mem_addr, e.addr);
        if (e.we) check("R2/R6 push data", mem_wdata, e.data);
      end
      if (mem_we) mem[mem_addr] = mem_wdata;
      else begin
        rd_addr <= mem_addr;
        rd_tok  <= rd_tok + 1;
      end
    end
  end

  // memory response and ready pattern, driven away from the active edge
  always @(negedge clk) begin
    stall_cnt++;
    mem_req_ready <= !stall || (stall_cnt % 3 == 0);
    if (rd_tok != rd_seen) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem.exists(rd_addr) ? mem[rd_addr] : 16'h0000;
      rd_seen    <= rd_tok;
    end else mem_rvalid <= 1'b0;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    vecs++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  task automatic wait_idle();
    int n = 0;
    do begin @(negedge clk); n++; end while (busy && n < 1000);
    if (busy) begin vecs++; fails++; $display("FAIL R9: busy stuck got 1 expected 0"); end
  endtask

  task automatic pulse_done(logic exp_irq, logic exp_nmi, string req);
    @(negedge clk);
    instr_done = 1;
    #1;
    check({req, " irq_ack"}, {15'd0, irq_ack}, {15'd0, exp_irq});
    check({req, " nmi_ack"}, {15'd0, nmi_ack}, {15'd0, exp_nmi});
    check("R9 busy at accept", {15'd0, busy}, {15'd0, exp_irq | exp_nmi});
    @(negedge clk);
    instr_done = 0;
  endtask

  task automatic do_reti();
    @(negedge clk);
    reti_cmd = 1;
    #1 check("R9 busy on return", {15'd0, busy}, 16'd1);
    @(negedge clk);
    reti_cmd = 0;
    wait_idle();
  endtask

  initial begin
    mem[16'hFFFE] = 16'h4400;
    mem[16'hFFFC] = 16'h5000;
    mem[16'hFFF2] = 16'h6000;

    // R8: reset fetches the reset vector, no writes
    expect_op(0, 16'hFFFE, 0);
    repeat (3) @(negedge clk);
    check("R8 sp in reset", sp, 16'h0400);
    rst_n = 1;
    wait_idle();
    check("R8 pc from reset vector", pc, 16'h4400);
    check("R8 sp", sp, 16'h0400);
    check("R8 sr", sr, 16'h0000);

    // R11: stepping
    repeat (3) begin @(negedge clk); step_pc = 1; end
    @(negedge clk); step_pc = 0;
    check("R11 pc step", pc, 16'h4406);

    // R4: maskable ignored with enable clear
    irq_req = 1;
    for (int i = 0; i < 3; i++) pulse_done(0, 0, "R4 masked");
    check("R4 sp untouched", sp, 16'h0400);
    check("R4 pc untouched", pc, 16'h4406);

    // R11: status load while idle
    @(negedge clk); sr_wr_en = 1; sr_wr_data = 16'h0009;
    @(negedge clk); sr_wr_en = 0;
    check("R11 sr load", sr, 16'h0009);

    // R1/R2/R3/R6/R9: maskable entry
    expect_op(1, 16'h03FE, 16'h4406);
    expect_op(1, 16'h03FC, 16'h0009);
    expect_op(0, 16'hFFF2, 0);
    pulse_done(1, 0, "R1 irq accept");
    irq_req = 0;
    step_pc = 1; sr_wr_en = 1; sr_wr_data = 16'hFFFF;
    @(negedge clk);
    step_pc = 0; sr_wr_en = 0;
    wait_idle();
    check("R3/R9 pc from irq vector", pc, 16'h6000);
    check("R2 sp after entry", sp, 16'h03FC);
    check("R6 enable cleared", sr, 16'h0001);

    // R5: both requests with enable set -> non-maskable wins
    @(negedge clk); sr_wr_en = 1; sr_wr_data = 16'h0008;
    @(negedge clk); sr_wr_en = 0;
    expect_op(1, 16'h03FA, 16'h6000);
    expect_op(1, 16'h03F8, 16'h0008);
    expect_op(0, 16'hFFFC, 0);
    irq_req = 1; nmi_req = 1;
    pulse_done(0, 1, "R5 priority");
    irq_req = 0; nmi_req = 0;
    wait_idle();
    check("R3 pc from nmi vector", pc, 16'h5000);
    check("R2 sp nested", sp, 16'h03F8);
    check("R6 sr after nmi entry", sr, 16'h0000);

    // R7: return from nested handler
    expect_op(0, 16'h03F8, 0);
    expect_op(0, 16'h03FA, 0);
    do_reti();
    check("R7 sr restored", sr, 16'h0008);
    check("R7 pc restored", pc, 16'h6000);
    check("R7 sp restored", sp, 16'h03FC);

    // R7/R10: return with a stalling memory
    stall = 1;
    expect_op(0, 16'h03FC, 0);
    expect_op(0, 16'h03FE, 0);
    do_reti();
    check("R7 sr enable restored", sr, 16'h0009);
    check("R7 pc resumes", pc, 16'h4406);
    check("R7 sp top", sp, 16'h0400);

    // R10: entry under stalls
    expect_op(1, 16'h03FE, 16'h4406);
    expect_op(1, 16'h03FC, 16'h0009);
    expect_op(0, 16'hFFF2, 0);
    irq_req = 1;
    pulse_done(1, 0, "R10 irq accept");
    irq_req = 0;
    wait_idle();
    check("R10 pc after stalled entry", pc, 16'h6000);
    check("R10 sp after stalled entry", sp, 16'h03FC);
    check("R2 scoreboard drained", 16'(exp_q.size()), 16'd0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule